// File: doc/BRIEF.md
# Flash Read-Timing Calibration Engine

This block searches for the fastest SPI clock divider and input-sampling delay at which reads through the flash read window return correct data. On a start pulse it first captures a reference block of words. The capture uses the slowest, safest setting: divider code 0, meaning /16, with single-bit normal reads and no dummy cycles. The engine then checks that the block holds enough varied data to tell a good setting from a bad one. If the data is too uniform, calibration is abandoned and the slow setting stays in place.

With usable data, the engine sweeps the candidate dividers from slow to fast. For each divider it walks twelve delay steps. At each step it re-reads the whole block several times and compares every word with the stored reference. A divider is accepted once three consecutive steps pass. Its delay field is then parked on the middle step of that run, which leaves one step of margin on each side. Each accepted divider replaces the previous one, so the fastest divider that works ends up on the divider output.

Reads go to the flash controller over a simple hold-until-valid port. The controller is expected to apply the divider and delay outputs to each read it performs.

Top module: `rtcal_engine`

## Requirements
- R1: After reset, `done`, `fail` and `rd_req` are low and both `sck_div` and `dly_cfg` are zero.
- R2: After `start`, the engine reads words 0 to REF_WORDS-1 once each, in order, with `rd_slow` high, `sck_div` = 0 (/16, single-bit normal read, no dummy cycles) and `dly_cfg` = 0.
- R3: A reference word is varied when it is neither 0x00000000 nor 0xFFFFFFFF. With fewer than MIN_VARIED varied words, the engine makes no further reads and ends with `done` and `fail` high, `sck_div` = 0 and `dly_cfg` = 0.
- R4: The candidate dividers are /5, /4, /3, /2 and /1, tried in that order, with `sck_div` codes 0xD, 0x6, 0xE, 0x7 and 0xF. A divider n is skipped, with no reads, when floor(HCLK_KHZ / n) >= `max_freq_khz`.
- R5: During step i (0 to 11) of divider n, the 4-bit field `dly_cfg[4n-1:4n-4]` holds {i even, i/2 in three bits}. No other field changes during the sweep.
- R6: A step re-reads words 0 to REF_WORDS-1 in order, REREADS times. It passes only if every word matches the reference. The first mismatching word ends the step, and the next read belongs to the next step.
- R7: When a third consecutive step passes, the divider's field is set to the code of the previous step, and the sweep moves on to the next faster divider. A failing step resets the run count to zero.
- R8: A divider that completes twelve steps without a run of three has its field returned to 0.
- R9: At the end of a sweep, `sck_div` shows the code of the fastest divider that succeeded, or 0 if none did. `done` is high for exactly one cycle, and `fail` stays low.
- R10: `rd_err` returned with `rd_valid` ends the run at once with `done` and `fail` high, `sck_div` = 0 and `dly_cfg` = 0.
- R11: A `start` pulse while a run is in progress has no effect on the read sequence or on the result.
- R12: Once `rd_req` is raised, it stays high with `rd_addr` unchanged until `rd_valid` is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration run (ignored while busy) |
| max_freq_khz | input | FREQ_W | Highest SPI clock the flash allows, in kHz |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Qualifies `done`: data unusable or controller error |
| rd_req | output | 1 | Read request to the flash controller |
| rd_addr | output | AW | Word index within the reference block |
| rd_slow | output | 1 | Request is a reference capture at the safe setting |
| rd_valid | input | 1 | Read data (or error) returned |
| rd_err | input | 1 | Controller error for the returned read |
| rd_data | input | 32 | Returned read word |
| sck_div | output | 4 | SPI clock divider code |
| dly_cfg | output | 20 | Input-delay fields, 4 bits per divider |

## Verification
A wrong delay code or wrong divider code would appear on `sck_div` and `dly_cfg` at the very next read request. The bench compares each request against a behavioural model of the sweep, so such an error is caught at that read. A broken run counter or a missing early abort would shift the number and order of reads, so the model detects it within one step, at most a few hundred cycles. A faulty varied-word count or a faulty divider-skip test shows up either at the first sweep read or in the final `done`/`fail` values.

// File: rtl/rtcal_pkg.sv
`timescale 1ns/1ps
package rtcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_CHECK,
    ST_NEXTDIV,
    ST_STEP,
    ST_READ,
    ST_EVAL,
    ST_FIN
  } cal_state_e;

  localparam logic [3:0] DIV_SAFE = 4'h0;

  // divider ratio n (1..5) -> controller divider code
  function automatic logic [3:0] div_code(input logic [2:0] n);
    logic [3:0] c;
    case (n)
      3'd1:    c = 4'hF;
      3'd2:    c = 4'h7;
      3'd3:    c = 4'hE;
      3'd4:    c = 4'h6;
      3'd5:    c = 4'hD;
      default: c = DIV_SAFE;
    endcase
    return c;
  endfunction

  // delay step index (0..11) -> 4-bit delay field
  function automatic logic [3:0] step_code(input logic [3:0] i);
    return {~i[0], i[3:1]};
  endfunction

endpackage

// File: rtl/rtcal_refbuf.sv
`timescale 1ns/1ps
module rtcal_refbuf #(
  parameter int WORDS      = 128,
  parameter int DW         = 32,
  parameter int MIN_VARIED = 64,
  parameter int AW         = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          usable
);
  localparam int CW = $clog2(WORDS + 1);
  localparam logic [CW:0] MIN_L = (CW+1)'(MIN_VARIED);

  logic [DW-1:0] mem_q [WORDS];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          varied;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wr_data;
  end

  assign rd_data = mem_q[addr];
  assign varied  = (wr_data != '0) && (wr_data != '1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                  cnt_d = '0;
    else if (wr_en && varied) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign usable = ({1'b0, cnt_q} >= MIN_L);

  // R3
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= WORDS);

endmodule

// File: rtl/rtcal_runtrack.sv
`timescale 1ns/1ps
module rtcal_runtrack #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic pass,
  output logic hit
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] run_q, run_d;

  assign hit = upd && pass && (run_q == RW'(RUN_LEN - 1));

  always_comb begin
    run_d = run_q;
    if (clr)             run_d = '0;
    else if (upd) begin
      if (!pass || hit)  run_d = '0;
      else               run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) < RUN_LEN);

endmodule

// File: rtl/rtcal_dlyreg.sv
`timescale 1ns/1ps
module rtcal_dlyreg #(
  parameter int NDIV = 5,
  parameter int FW   = 4,
  parameter int SW   = $clog2(NDIV + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 set_en,
  input  logic [SW-1:0]        sel,
  input  logic [FW-1:0]        code,
  output logic [NDIV*FW-1:0]   cfg
);
  for (genvar g = 0; g < NDIV; g++) begin : g_field
    logic [FW-1:0] f_q, f_d;
    logic          hit_sel;

    assign hit_sel = set_en && (sel == SW'(g + 1));

    always_comb begin
      f_d = f_q;
      if (clr)          f_d = '0;
      else if (hit_sel) f_d = code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= '0;
      else        f_q <= f_d;
    end

    assign cfg[g*FW +: FW] = f_q;
  end

endmodule

// File: rtl/rtcal_engine.sv
`timescale 1ns/1ps
module rtcal_engine
  import rtcal_pkg::*;
#(
  parameter int HCLK_KHZ   = 198000,
  parameter int FREQ_W     = 20,
  parameter int REF_WORDS  = 128,
  parameter int MIN_VARIED = 64,
  parameter int REREADS    = 10,
  parameter int RUN_LEN    = 3,
  parameter int AW         = $clog2(REF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] max_freq_khz,
  output logic              done,
  output logic              fail,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic              rd_slow,
  input  logic              rd_valid,
  input  logic              rd_err,
  input  logic [31:0]       rd_data,
  output logic [3:0]        sck_div,
  output logic [19:0]       dly_cfg
);
  localparam int NDIV  = 5;
  localparam int NSTEP = 12;
  localparam int SW    = $clog2(NDIV + 1);
  localparam int RRW   = (REREADS > 1) ? $clog2(REREADS) : 1;
  localparam int PW    = FREQ_W + 4;
  localparam logic [PW-1:0]  HCLK_L  = PW'(HCLK_KHZ);
  localparam logic [AW-1:0]  LAST_W  = AW'(REF_WORDS - 1);
  localparam logic [RRW-1:0] LAST_RR = RRW'(REREADS - 1);

  cal_state_e     state_q, state_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [RRW-1:0] rr_q, rr_d;
  logic [3:0]     step_q, step_d;
  logic [SW-1:0]  div_q, div_d;
  logic [SW-1:0]  best_q, best_d;
  logic [3:0]     sck_q, sck_d;
  logic           fail_q, fail_d;
  logic           pass_q, pass_d;

  logic           buf_clr, buf_wr, usable;
  logic [31:0]    ref_word;
  logic           run_clr, run_upd, run_hit;
  logic           dly_clr, dly_set;
  logic [3:0]     dly_code;
  logic [PW-1:0]  lim_prod;
  logic           skip_div, mismatch;

  rtcal_refbuf #(
    .WORDS(REF_WORDS), .DW(32), .MIN_VARIED(MIN_VARIED), .AW(AW)
  ) u_refbuf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .addr(addr_q), .wr_data(rd_data), .rd_data(ref_word), .usable(usable)
  );

  rtcal_runtrack #(.RUN_LEN(RUN_LEN)) u_runtrack (
    .clk(clk), .rst_n(rst_n), .clr(run_clr), .upd(run_upd),
    .pass(pass_q), .hit(run_hit)
  );

  rtcal_dlyreg #(.NDIV(NDIV), .FW(4), .SW(SW)) u_dlyreg (
    .clk(clk), .rst_n(rst_n), .clr(dly_clr), .set_en(dly_set),
    .sel(div_q), .code(dly_code), .cfg(dly_cfg)
  );

  // divider n is skipped when HCLK/n >= max, i.e. HCLK >= max*n
  assign lim_prod = PW'(max_freq_khz) * PW'(div_q);
  assign skip_div = (lim_prod <= HCLK_L);
  assign mismatch = (rd_data != ref_word);

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    rr_d     = rr_q;
    step_d   = step_q;
    div_d    = div_q;
    best_d   = best_q;
    sck_d    = sck_q;
    fail_d   = fail_q;
    pass_d   = pass_q;
    buf_clr  = 1'b0;
    buf_wr   = 1'b0;
    run_clr  = 1'b0;
    run_upd  = 1'b0;
    dly_clr  = 1'b0;
    dly_set  = 1'b0;
    dly_code = 4'h0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_REF;
          addr_d  = '0;
          best_d  = '0;
          sck_d   = DIV_SAFE;
          fail_d  = 1'b0;
          buf_clr = 1'b1;
          dly_clr = 1'b1;
        end
      end
      ST_REF: begin
        if (rd_valid) begin
          if (rd_err) begin
            sck_d   = DIV_SAFE;
            dly_clr = 1'b1;
            fail_d  = 1'b1;
            state_d = ST_FIN;
          end else begin
            buf_wr = 1'b1;
            if (addr_q == LAST_W) state_d = ST_CHECK;
            else                  addr_d  = addr_q + 1'b1;
          end
        end
      end
      ST_CHECK: begin
        if (usable) begin
          div_d   = SW'(NDIV);
          state_d = ST_NEXTDIV;
        end else begin
          fail_d  = 1'b1;
          state_d = ST_FIN;
        end
      end
      ST_NEXTDIV: begin
        if (div_q == '0) begin
          sck_d   = (best_q != '0) ? div_code(best_q) : DIV_SAFE;
          state_d = ST_FIN;
        end else if (skip_div) begin
          div_d = div_q - 1'b1;
        end else begin
          sck_d   = div_code(div_q);
          step_d  = '0;
          run_clr = 1'b1;
          state_d = ST_STEP;
        end
      end
      ST_STEP: begin
        dly_set  = 1'b1;
        dly_code = step_code(step_q);
        addr_d   = '0;
        rr_d     = '0;
        state_d  = ST_READ;
      end
      ST_READ: begin
        if (rd_valid) begin
          if (rd_err) begin
            sck_d   = DIV_SAFE;
            dly_clr = 1'b1;
            fail_d  = 1'b1;
            state_d = ST_FIN;
          end else if (mismatch) begin
            pass_d  = 1'b0;
            state_d = ST_EVAL;
          end else if (addr_q == LAST_W) begin
            addr_d = '0;
            if (rr_q == LAST_RR) begin
              pass_d  = 1'b1;
              state_d = ST_EVAL;
            end else begin
              rr_d = rr_q + 1'b1;
            end
          end else begin
            addr_d = addr_q + 1'b1;
          end
        end
      end
      ST_EVAL: begin
        run_upd = 1'b1;
        if (run_hit) begin
          dly_set  = 1'b1;
          dly_code = step_code(step_q - 4'd1);
          best_d   = div_q;
          div_d    = div_q - 1'b1;
          state_d  = ST_NEXTDIV;
        end else if (step_q == 4'(NSTEP - 1)) begin
          dly_set  = 1'b1;
          dly_code = 4'h0;
          div_d    = div_q - 1'b1;
          state_d  = ST_NEXTDIV;
        end else begin
          step_d  = step_q + 4'd1;
          state_d = ST_STEP;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rr_q    <= '0;
      step_q  <= '0;
      div_q   <= '0;
      best_q  <= '0;
      sck_q   <= DIV_SAFE;
      fail_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rr_q    <= rr_d;
      step_q  <= step_d;
      div_q   <= div_d;
      best_q  <= best_d;
      sck_q   <= sck_d;
      fail_q  <= fail_d;
      pass_q  <= pass_d;
    end
  end

  assign rd_req  = (state_q == ST_REF) || (state_q == ST_READ);
  assign rd_slow = (state_q == ST_REF);
  assign rd_addr = addr_q;
  assign sck_div = sck_q;
  assign done    = (state_q == ST_FIN);
  assign fail    = done && fail_q;

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R2
  slow_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slow |-> (sck_div == DIV_SAFE));

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_slow && !rd_valid) |=> ($stable(dly_cfg) && $stable(sck_div)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/rtcal_engine_bench.sv
`timescale 1ns/1ps
module rtcal_engine_bench;
  localparam int HCLK  = 198000;
  localparam int WORDS = 16;
  localparam int MINV  = 8;
  localparam int RR    = 10;
  localparam int AW    = 4;

  typedef struct {
    int          addr;
    logic [3:0]  dv;
    logic [19:0] dly;
    bit          slow;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [19:0] max_freq_khz;
  logic        done, fail, rd_req, rd_slow, rd_valid, rd_err;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data;
  logic [3:0]  sck_div;
  logic [19:0] dly_cfg;

  always #4 clk = ~clk;

  rtcal_engine #(
    .HCLK_KHZ(HCLK), .FREQ_W(20), .REF_WORDS(WORDS),
    .MIN_VARIED(MINV), .REREADS(RR), .RUN_LEN(3), .AW(AW)
  ) u_rtcal_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .max_freq_khz(max_freq_khz),
    .done(done), .fail(fail), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_slow(rd_slow), .rd_valid(rd_valid), .rd_err(rd_err),
    .rd_data(rd_data), .sck_div(sck_div), .dly_cfg(dly_cfg)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  rec_t exp_q[$];
  logic [11:0] good_mask [1:5];
  int pat_mode = 0;
  int err_at = -1;
  int resp_cnt;
  bit exp_fail;
  logic [3:0]  exp_div;
  logic [19:0] exp_dly;

  function automatic logic [31:0] pat(int a);
    if (pat_mode == 1 && a >= 3) return 32'h0;
    return 32'h2468ACE1 ^ (32'(a) * 32'h01030507);
  endfunction

  function automatic logic [3:0] dcode(int n);
    case (n)
      1: return 4'hF;
      2: return 4'h7;
      3: return 4'hE;
      4: return 4'h6;
      5: return 4'hD;
      default: return 4'h0;
    endcase
  endfunction

  function automatic int n_of(logic [3:0] c);
    for (int n = 1; n <= 5; n++) if (dcode(n) == c) return n;
    return 0;
  endfunction

  function automatic logic [3:0] scode(int i);
    logic [3:0] c;
    c[2:0] = 3'(i / 2);
    c[3]   = (i % 2 == 0);
    return c;
  endfunction

  function automatic int step_of(logic [3:0] f);
    return 2 * int'(f[2:0]) + (f[3] ? 0 : 1);
  endfunction

  function automatic logic [31:0] resp_word(int a, logic slow, logic [3:0] dv,
                                            logic [19:0] dl);
    logic [31:0] d;
    int n;
    d = pat(a);
    n = n_of(dv);
    if (!slow && n > 0 && a == 3 && !good_mask[n][step_of(dl[4*n-4 +: 4])])
      d = d ^ 32'h1;
    return d;
  endfunction

  // flash controller stand-in
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
      resp_cnt <= 0;
    end else begin
      rd_valid <= rd_req && !rd_valid;
      rd_err   <= 1'b0;
      if (rd_req && !rd_valid) begin
        rd_data  <= resp_word(int'(rd_addr), rd_slow, sck_div, dly_cfg);
        rd_err   <= (resp_cnt == err_at);
        resp_cnt <= resp_cnt + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural model of the full read sequence and the final result
  task automatic build_model(int maxf);
    int cnt;
    logic [19:0] dl;
    int best;
    exp_q.delete();
    cnt = 0;
    for (int w = 0; w < WORDS; w++) begin
      exp_q.push_back('{w, 4'h0, 20'h0, 1'b1});
      if (pat(w) != 32'h0 && pat(w) != 32'hFFFFFFFF) cnt++;
    end
    if (cnt < MINV) begin
      exp_fail = 1; exp_div = 4'h0; exp_dly = 20'h0;
      return;
    end
    dl = 20'h0;
    best = 0;
    for (int n = 5; n >= 1; n--) begin
      int run;
      bit found;
      if (HCLK / n >= maxf) continue;
      run = 0;
      found = 0;
      for (int i = 0; i < 12 && !found; i++) begin
        bit ok;
        bit stop;
        dl[4*n-4 +: 4] = scode(i);
        ok = good_mask[n][i];
        stop = 0;
        for (int r = 0; r < RR && !stop; r++) begin
          for (int w = 0; w < WORDS && !stop; w++) begin
            exp_q.push_back('{w, dcode(n), dl, 1'b0});
            if (!ok && w == 3) stop = 1;
          end
        end
        if (ok) begin
          run++;
          if (run == 3) begin
            found = 1;
            dl[4*n-4 +: 4] = scode(i - 1);
          end
        end else begin
          run = 0;
        end
      end
      if (found) best = n;
      else       dl[4*n-4 +: 4] = 4'h0;
    end
    exp_fail = 0;
    exp_div  = dcode(best);
    exp_dly  = dl;
  endtask

  // per-read comparison against the model
  task automatic monitor();
    bit pend = 0;
    logic [AW-1:0] pend_addr = '0;
    forever begin
      @(negedge clk);
      if (rst_n && pend && !(rd_req && rd_addr == pend_addr))
        chk(0, "R12", "request dropped or address moved", 64'(rd_addr), 64'(pend_addr));
      pend = rd_req && !rd_valid;
      pend_addr = rd_addr;
      if (rst_n && rd_req && rd_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6", "unexpected read", 64'(rd_addr), 64'hFFFF);
        end else begin
          rec_t e;
          e = exp_q.pop_front();
          chk(rd_addr == AW'(e.addr) && sck_div == e.dv && dly_cfg == e.dly && rd_slow == e.slow,
              e.slow ? "R2" : "R6", "read request",
              {11'b0, rd_slow, sck_div, dly_cfg, 28'(rd_addr)},
              {11'b0, e.slow, e.dv, e.dly, 28'(e.addr)});
        end
      end
    end
  endtask

  task automatic run_case(string tag, int maxf, int err_rel, bit poke);
    int cyc;
    build_model(maxf);
    if (err_rel >= 0) begin
      while (exp_q.size() > err_rel + 1) void'(exp_q.pop_back());
      exp_fail = 1; exp_div = 4'h0; exp_dly = 20'h0;
      err_at = resp_cnt + err_rel;
    end else begin
      err_at = -1;
    end
    max_freq_khz = 20'(maxf);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 60000) begin
      if (poke && cyc == 300) start = 1'b1;
      if (poke && cyc == 301) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      chk(0, tag, "watchdog: no done", 64'(cyc), 64'd0);
      return;
    end
    chk(exp_q.size() == 0, tag, "reads left unissued", 64'(exp_q.size()), 64'd0);
    chk(fail == exp_fail, tag, "fail flag", 64'(fail), 64'(exp_fail));
    chk(sck_div == exp_div, tag, "divider code", 64'(sck_div), 64'(exp_div));
    chk(dly_cfg == exp_dly, tag, "delay fields", 64'(dly_cfg), 64'(exp_dly));
    @(negedge clk);
    chk(!done, "R9", "done longer than one cycle", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    max_freq_khz = '0;
    for (int n = 1; n <= 5; n++) good_mask[n] = 12'h0;
    fork
      monitor();
    join_none
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !fail && !rd_req, "R1", "control outputs at reset",
        {61'b0, done, fail, rd_req}, 64'd0);
    chk(sck_div == 4'h0 && dly_cfg == 20'h0, "R1", "timing outputs at reset",
        {40'b0, sck_div, dly_cfg}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rd_req && !done, "R1", "idle after reset release", {62'b0, rd_req, done}, 64'd0);

    // R3 uniform reference data
    pat_mode = 1;
    run_case("R3", 150000, -1, 0);
    pat_mode = 0;

    // R7 R8 R11: mixed windows, start pulsed mid-run
    good_mask[5] = 12'h1FC;
    good_mask[4] = 12'hFFF;
    good_mask[3] = 12'h01B;
    good_mask[2] = 12'h0E0;
    good_mask[1] = 12'h000;
    run_case("R11", 150000, -1, 1);
    chk(exp_div == 4'h7, "R7", "model picks /2", 64'(exp_div), 64'h7);

    // R4: every divider too fast for the flash
    run_case("R4", 30000, -1, 0);

    // R4 R9: all five dividers tried, /1 wins
    for (int n = 1; n <= 5; n++) good_mask[n] = 12'hFF0;
    run_case("R9", 300000, -1, 0);

    // R10: controller error during the sweep
    good_mask[5] = 12'h1FC;
    good_mask[4] = 12'hFFF;
    good_mask[3] = 12'h01B;
    good_mask[2] = 12'h0E0;
    run_case("R10", 150000, WORDS + 40, 0);

    // R8: nothing ever passes
    for (int n = 1; n <= 5; n++) good_mask[n] = 12'h000;
    run_case("R8", 150000, -1, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired before the run ended");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule